// File: doc/BRIEF.md
# I2C Clock Phase Timing Generator

This block turns a fast functional clock into the timing events an I2C master's transfer engine needs. A prescaler divides the functional clock by its programmed value plus one, giving an internal module tick of roughly 7 to 12 MHz. For example, a 12 MHz input uses a divider setting of 0, and a 13 MHz or 19.2 MHz input uses a setting of 1. Two further values set how many module ticks SCL spends low and how many it spends high. Each phase is stretched by a fixed offset that shrinks as the prescaler grows.

While the transfer engine holds `bus_req` high, the block steps through a low phase and then a high phase, over and over. It tells the engine when SCL should rise and fall, when SDA may change (the middle of the low phase) and when SDA should be sampled (the middle of the high phase). A host programs the three timing values through a 16-bit write port. Those values are staged, and they reach the counters only while the engine is idle. The usual settings give 100 kHz standard mode and 400 kHz fast mode. For example, with a 12 MHz input and a divider setting of 0, a phase value of 53 in both registers gives 100 kHz.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset the divider setting is 0 and both phase values are 53. With these values, a run produces SCL low for 60 clocks and then high for 60 clocks.
- R2: One module tick occurs every (P+1) functional clocks, where P is the applied divider setting.
- R3: A phase lasts V + 7 − min(P,2) module ticks, where V is that phase's value. For example, V = 0 with P = 3 gives a phase of 5 ticks.
- R4: The low phase and the high phase use their own values independently.
- R5: `tick_sda_drive` pulses for one clock during the last functional clock of low-phase module tick number floor(L/2), counting from 0, where L is the low-phase length in ticks.
- R6: `tick_sda_sample` pulses for one clock in the same way inside the high phase, using the high-phase length.
- R7: Each run begins with SCL low. `tick_scl_rise` pulses in the last clock of a low phase and `tick_scl_fall` pulses in the last clock of a high phase. At most one tick output is high in any clock.
- R8: While `bus_req` is low, `scl_level` is 1 and every tick output is 0. The next run restarts both counters from zero.
- R9: A write made while `bus_req` is high changes nothing in the current run. The new value takes effect in the first run after an idle clock.
- R10: The write addresses are 0 for the divider setting, 1 for the low-phase value and 2 for the high-phase value. Each register keeps only the low 8 bits of `cfg_wdata`. A write to address 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 16 | Write data |
| bus_req | input | 1 | Transfer engine requests bus activity |
| scl_level | output | 1 | SCL level the engine should present (1 = released) |
| tick_scl_rise | output | 1 | Last clock of a low phase |
| tick_scl_fall | output | 1 | Last clock of a high phase |
| tick_sda_drive | output | 1 | SDA may change now (middle of the low phase) |
| tick_sda_sample | output | 1 | Sample SDA now (middle of the high phase) |

## Verification
The hardest condition to reach is a host write that lands in the middle of a run. The risk there is that a new value slips into the counters before the engine goes idle. The stimulus issues the write halfway through a long observation window and keeps comparing every cycle against the old timing until the window ends. It then drops `bus_req` and confirms that the next run follows the new value. A divider setting above 2 is also driven, to reach the capped offset.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;

  localparam logic [1:0] ADDR_DIV = 2'd0;
  localparam logic [1:0] ADDR_LO  = 2'd1;
  localparam logic [1:0] ADDR_HI  = 2'd2;

  localparam int OFS_BASE = 7;
  localparam int OFS_CAP  = 2;
endpackage

// File: rtl/tg_cfg_regs.sv
module tg_cfg_regs
  import scl_tg_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIV_W  = 8,
  parameter int PH_W   = 8,
  parameter logic [DIV_W-1:0] RST_DIV = '0,
  parameter logic [PH_W-1:0]  RST_LO  = PH_W'(53),
  parameter logic [PH_W-1:0]  RST_HI  = PH_W'(53)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hold,
  output logic [DIV_W-1:0]  div_q,
  output logic [PH_W-1:0]   lo_q,
  output logic [PH_W-1:0]   hi_q
);
  logic [DIV_W-1:0] stg_div, stg_div_d, div_d;
  logic [PH_W-1:0]  stg_lo, stg_lo_d, lo_d;
  logic [PH_W-1:0]  stg_hi, stg_hi_d, hi_d;

  always_comb begin
    stg_div_d = stg_div;
    stg_lo_d  = stg_lo;
    stg_hi_d  = stg_hi;
    if (wr_en) begin
      case (wr_addr)
        ADDR_DIV: stg_div_d = wr_data[DIV_W-1:0];
        ADDR_LO:  stg_lo_d  = wr_data[PH_W-1:0];
        ADDR_HI:  stg_hi_d  = wr_data[PH_W-1:0];
        default:  ;
      endcase
    end
    div_d = hold ? div_q : stg_div;
    lo_d  = hold ? lo_q  : stg_lo;
    hi_d  = hold ? hi_q  : stg_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_div <= RST_DIV;
      stg_lo  <= RST_LO;
      stg_hi  <= RST_HI;
      div_q   <= RST_DIV;
      lo_q    <= RST_LO;
      hi_q    <= RST_HI;
    end else begin
      stg_div <= stg_div_d;
      stg_lo  <= stg_lo_d;
      stg_hi  <= stg_hi_d;
      div_q   <= div_d;
      lo_q    <= lo_d;
      hi_q    <= hi_d;
    end
  end

  // R9
  applied_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && $past(hold)) |-> ($stable(div_q) && $stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/tg_prescaler.sv
module tg_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             mtick
);
  logic [DIV_W-1:0] pc, pc_d;

  assign mtick = run && (pc == div_val);

  always_comb begin
    if (!run || mtick) pc_d = '0;
    else               pc_d = pc + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_d;
  end

  // R2
  pc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pc <= div_val));
  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pc == '0));
endmodule

// File: rtl/tg_phase_ctr.sv
module tg_phase_ctr
  import scl_tg_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int PH_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             mtick,
  input  logic [DIV_W-1:0] div_val,
  input  logic [PH_W-1:0]  lo_val,
  input  logic [PH_W-1:0]  hi_val,
  output scl_phase_e       phase,
  output logic             t_rise,
  output logic             t_fall,
  output logic             t_mid_lo,
  output logic             t_mid_hi
);
  localparam int CNT_W = PH_W + 1;

  logic [CNT_W-1:0] cnt, cnt_d;
  scl_phase_e       phase_d;
  logic [1:0]       cap;
  logic [CNT_W-1:0] ofs, len_lo, len_hi, cur_len, half;
  logic             last;

  always_comb begin
    cap     = (div_val > DIV_W'(OFS_CAP)) ? 2'(OFS_CAP) : div_val[1:0];
    ofs     = CNT_W'(OFS_BASE) - CNT_W'(cap);
    len_lo  = {1'b0, lo_val} + ofs;
    len_hi  = {1'b0, hi_val} + ofs;
    cur_len = (phase == PH_HIGH) ? len_hi : len_lo;
    half    = cur_len >> 1;
    last    = (cnt == cur_len - CNT_W'(1));
  end

  always_comb begin
    cnt_d   = cnt;
    phase_d = phase;
    if (!run) begin
      cnt_d   = '0;
      phase_d = PH_LOW;
    end else if (mtick) begin
      if (last) begin
        cnt_d   = '0;
        phase_d = (phase == PH_LOW) ? PH_HIGH : PH_LOW;
      end else begin
        cnt_d = cnt + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= PH_LOW;
    end else begin
      cnt   <= cnt_d;
      phase <= phase_d;
    end
  end

  assign t_rise   = mtick && (phase == PH_LOW)  && last;
  assign t_fall   = mtick && (phase == PH_HIGH) && last;
  assign t_mid_lo = mtick && (phase == PH_LOW)  && (cnt == half);
  assign t_mid_hi = mtick && (phase == PH_HIGH) && (cnt == half);

  // R3
  cnt_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt < cur_len));
  // R7
  phase_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t_rise && run) |=> (!run || phase == PH_HIGH));
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DIV_W       = 8,
  parameter int PH_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              bus_req,
  output logic              scl_level,
  output logic              tick_scl_rise,
  output logic              tick_scl_fall,
  output logic              tick_sda_drive,
  output logic              tick_sda_sample
);
  logic             rst_sync_n;
  logic [DIV_W-1:0] div_q;
  logic [PH_W-1:0]  lo_q, hi_q;
  logic             mtick;
  scl_phase_e       phase;

  generate
    if (SYNC_STAGES <= 1) begin : g_rs1
      logic rs;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs <= 1'b0;
        else        rs <= 1'b1;
      end
      assign rst_sync_n = rs;
    end else begin : g_rsn
      logic [SYNC_STAGES-1:0] rs;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs <= '0;
        else        rs <= {rs[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_sync_n = rs[SYNC_STAGES-1];
    end
  endgenerate

  tg_cfg_regs #(
    .DATA_W(DATA_W), .DIV_W(DIV_W), .PH_W(PH_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(cfg_wr), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .hold(bus_req),
    .div_q(div_q), .lo_q(lo_q), .hi_q(hi_q)
  );

  tg_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .run(bus_req), .div_val(div_q), .mtick(mtick)
  );

  tg_phase_ctr #(.DIV_W(DIV_W), .PH_W(PH_W)) u_ph (
    .clk(clk), .rst_n(rst_sync_n), .run(bus_req), .mtick(mtick),
    .div_val(div_q), .lo_val(lo_q), .hi_val(hi_q), .phase(phase),
    .t_rise(tick_scl_rise), .t_fall(tick_scl_fall),
    .t_mid_lo(tick_sda_drive), .t_mid_hi(tick_sda_sample)
  );

  assign scl_level = !bus_req || (phase == PH_HIGH);

  // R7
  one_tick_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({tick_scl_rise, tick_scl_fall, tick_sda_drive, tick_sda_sample}));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !bus_req |-> (scl_level && !tick_scl_rise && !tick_scl_fall
                  && !tick_sda_drive && !tick_sda_sample));
  // R5
  drive_in_low_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    tick_sda_drive |-> !scl_level);
endmodule

// File: tb/scl_timing_gen_test.sv
`timescale 1ns/1ps
module scl_timing_gen_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr;
  logic [1:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        bus_req;
  logic        scl_level, t_rise, t_fall, t_drv, t_smp;
  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  scl_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .bus_req(bus_req), .scl_level(scl_level),
    .tick_scl_rise(t_rise), .tick_scl_fall(t_fall),
    .tick_sda_drive(t_drv), .tick_sda_sample(t_smp)
  );

  task automatic report(string tag, int bad, int act, int exp, int cyc);
    checks++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: %0d bad cycles, first at cycle %0d actual %0d expected %0d",
               tag, bad, cyc, act, exp);
    end
  endtask

  function automatic int plen(int v, int p);
    return v + 7 - ((p > 2) ? 2 : p);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0; bus_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Runs bus_req for n cycles and compares every cycle with the timing
  // model for (p, lo, hi); optionally issues a write halfway through.
  task automatic run_check(string tag, int p, int lo, int hi, int n,
                           bit mid_wr, logic [1:0] wa, logic [15:0] wd);
    int pp = p + 1;
    int llo = plen(lo, p);
    int lhi = plen(hi, p);
    int per = (llo + lhi) * pp;
    int b_scl = 0, b_r = 0, b_f = 0, b_d = 0, b_s = 0;
    int f_scl = 0, f_r = 0, f_f = 0, f_d = 0, f_s = 0;
    int a_scl = 0, a_r = 0, a_f = 0, a_d = 0, a_s = 0;
    @(negedge clk);
    bus_req = 1'b1;
    for (int i = 0; i < n; i++) begin
      int t;
      logic e_scl, e_r, e_f, e_d, e_s;
      if (i > 0) @(negedge clk);
      if (mid_wr && i == n / 2) begin
        cfg_wr = 1'b1; cfg_addr = wa; cfg_wdata = wd;
      end else begin
        cfg_wr = 1'b0;
      end
      #1;
      t = i % per;
      e_scl = (t >= llo * pp);
      e_r = (t == llo * pp - 1);
      e_f = (t == per - 1);
      e_d = (t == (llo / 2) * pp + pp - 1);
      e_s = (t == llo * pp + (lhi / 2) * pp + pp - 1);
      if (scl_level !== e_scl) begin if (b_scl == 0) begin f_scl = i; a_scl = scl_level; end b_scl++; end
      if (t_rise !== e_r) begin if (b_r == 0) begin f_r = i; a_r = t_rise; end b_r++; end
      if (t_fall !== e_f) begin if (b_f == 0) begin f_f = i; a_f = t_fall; end b_f++; end
      if (t_drv !== e_d) begin if (b_d == 0) begin f_d = i; a_d = t_drv; end b_d++; end
      if (t_smp !== e_s) begin if (b_s == 0) begin f_s = i; a_s = t_smp; end b_s++; end
    end
    @(negedge clk);
    bus_req = 1'b0; cfg_wr = 1'b0;
    report({tag, " R7 scl_level"}, b_scl, a_scl, 1 - a_scl, f_scl);
    report({tag, " R7 tick_scl_rise"}, b_r, a_r, 1 - a_r, f_r);
    report({tag, " R7 tick_scl_fall"}, b_f, a_f, 1 - a_f, f_f);
    report({tag, " R5 tick_sda_drive"}, b_d, a_d, 1 - a_d, f_d);
    report({tag, " R6 tick_sda_sample"}, b_s, a_s, 1 - a_s, f_s);
    repeat (3) @(negedge clk);
  endtask

  task automatic idle_check(string tag, int n);
    int bad = 0, first = 0, act = 0;
    bus_req = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (scl_level !== 1'b1 || t_rise || t_fall || t_drv || t_smp) begin
        if (bad == 0) begin first = i; act = {scl_level, t_rise, t_fall, t_drv, t_smp}; end
        bad++;
      end
    end
    report({tag, " R8 idle outputs"}, bad, act, 16, first);
  endtask

  task automatic test_reset();          // R1, R8
    do_reset();
    idle_check("R1 after reset", 10);
    run_check("R1 reset values", 0, 53, 53, 250, 1'b0, 2'd0, 16'd0);
  endtask

  task automatic test_div1();           // R2, R3, R4
    wr(2'd0, 16'd1); wr(2'd1, 16'd2); wr(2'd2, 16'd10);
    repeat (2) @(negedge clk);
    run_check("R2 R4 div1", 1, 2, 10, 120, 1'b0, 2'd0, 16'd0);
  endtask

  task automatic test_cap();            // R3
    wr(2'd0, 16'd3); wr(2'd1, 16'd0); wr(2'd2, 16'd3);
    repeat (2) @(negedge clk);
    run_check("R3 capped offset", 3, 0, 3, 150, 1'b0, 2'd0, 16'd0);
  endtask

  task automatic test_div2();           // R2, R3
    wr(2'd0, 16'h0102); wr(2'd1, 16'h0301); wr(2'd2, 16'd1);
    repeat (2) @(negedge clk);
    run_check("R10 R2 div2 low bits", 2, 1, 1, 100, 1'b0, 2'd0, 16'd0);
  endtask

  task automatic test_hold();           // R9
    wr(2'd0, 16'd0); wr(2'd1, 16'd4); wr(2'd2, 16'd9);
    repeat (2) @(negedge clk);
    run_check("R9 write during run", 0, 4, 9, 120, 1'b1, 2'd1, 16'h0020);
    idle_check("R9 idle gap", 2);
    run_check("R9 applied after idle", 0, 32, 9, 150, 1'b0, 2'd0, 16'd0);
  endtask

  task automatic test_bad_addr();       // R10
    wr(2'd3, 16'hFFFF);
    repeat (2) @(negedge clk);
    run_check("R10 address 3 ignored", 0, 32, 9, 120, 1'b0, 2'd0, 16'd0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_div1();
    test_cap();
    test_div2();
    test_hold();
    test_bad_addr();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule